// File: doc/BRIEF.md
# Real-Time Clock with Alarm and Interrupt Flags

This block keeps wall-clock time (seconds, minutes, hours) and a simplified day/month calendar. It advances the time once for every pulse on a 1 Hz enable input. All time, calendar and alarm bytes are held in either BCD or plain binary, and hours run in either 24-hour or 12-hour form. A control bit can freeze counting so that software can load a new time without a carry landing halfway through the load.

Three event flags are kept:
- The periodic flag is set by a separate rate tick.
- The alarm flag is set when the time equals three alarm bytes. Any alarm byte can be made a wildcard.
- The update-done flag is set after each one-second step.

Each flag has an enable. Any flag whose enable is set pulls the active-low interrupt output down. Reading the flag register returns the flags and clears them. A single synchronous register port with a 4-bit address gives access to everything.

The register map is as follows. Address 0 holds seconds, 1 the seconds alarm, 2 minutes, 3 the minutes alarm, 4 hours, 5 the hours alarm, 6 the day, 7 the month, 8 the control register and 9 the flag register. All other addresses read 0.

Top module: `rtc_core`

## Requirements
- R1: With control bit 7 (freeze) at 0, each cycle with `tick_1hz` high advances seconds by one at the next clock edge. Wrapping seconds from 59 to 0 carries into minutes, and wrapping minutes from 59 to 0 carries into hours.
- R2: With freeze at 1, ticks leave seconds, minutes, hours, day and month unchanged. Register writes still load them.
- R3: Control bit 2 at 0 makes every time and calendar byte count in BCD (09 steps to 0x10, 0x59 wraps to 0x00). At 1 they count in binary (9 steps to 0x0A, 59 wraps to 0).
- R4: Control bit 1 at 1 selects 24-hour counting. 23:59:59 steps to 00:00:00 and carries into the day.
- R5: Control bit 1 at 0 selects 12-hour counting. Hours bit 7 is the PM marker and the count runs 12, 1, ..., 11. The PM marker toggles on 11:59:59 to 12:00:00, and the step from 11:59:59 PM to 12:00:00 AM carries into the day.
- R6: The alarm flag (flag bit 5) is set one clock edge after a one-second step when seconds, minutes and hours equal their alarm bytes. An alarm byte whose bits 7:6 are 11 matches any value.
- R7: The update-done flag (flag bit 4) is set one clock edge after each one-second step taken with freeze at 0.
- R8: The periodic flag (flag bit 6) is set on the edge after each `tick_per` pulse, whatever the value of its enable.
- R9: `irq_n` is low exactly when a flag is set together with its enable. Flag bit 7 shows that condition and flag bits 3:0 read 0. Reading address 9 with `rd_en` clears all flags, which raises `irq_n` one edge later.
- R10: Control register bits from 7 down to 0 are: freeze, periodic enable, alarm enable, update enable, 0, data mode, 24-hour, and 0 (daylight-saving, not available).
- R11: While `por_n` is low, all three enables and all flags are cleared and `irq_n` is high. The freeze, data-mode and 24-hour bits, the time and the calendar keep their values.
- R12: A control write that raises freeze from 0 to 1 clears the update enable, whatever value is written to it. A write with freeze already at 1 sets the enable as written.
- R13: Day counts from 1 to `DAYS` and then wraps to 1, carrying into the month. Month counts from 1 to 12 and then wraps to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| tick_per | input | 1 | One-cycle pulse at the periodic rate |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears flags at address 9) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A wrong counter state shows up on the next read of the affected byte, at the latest on the carry edge that follows. A bad carry gate puts a wrong value on the next byte up within one tick. A flag or enable that is wrong shows on `irq_n` within one edge of the event or read that should have moved it. A control bit that is lost or wrongly cleared by reset or by raising freeze shows on the next read of address 8, or in the next tick's counting. The directed scenarios place times just before each wrap so that every carry path can be seen in a single tick.

// File: rtl/rtc_core.sv
module rtc_core #(
  parameter int DAYS = 30
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       tick_1hz,
  input  logic       tick_per,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq_n
);
  localparam logic [7:0] DMAX = 8'(DAYS);

  logic [7:0] sec_q, min_q, hr_q, day_q, mon_q, al_s, al_m, al_h;
  logic set_q, dm, h24;
  logic pie, aie, uie, pf, af, uf, upd_q;

  function automatic logic [7:0] fmt(input logic [7:0] n, input logic bin);
    fmt = bin ? n : (((n / 8'd10) << 4) | (n % 8'd10));
  endfunction

  function automatic logic [7:0] nxt(input logic [7:0] v, input logic [7:0] top,
                                     input logic [7:0] bot, input logic bin);
    if (v == fmt(top, bin))            nxt = fmt(bot, bin);
    else if (!bin && v[3:0] == 4'd9)  nxt = {v[7:4] + 4'd1, 4'd0};
    else                              nxt = v + 8'd1;
  endfunction

  function automatic logic [6:0] inc7(input logic [6:0] v, input logic bin);
    if (!bin && v[3:0] == 4'd9) inc7 = {v[6:4] + 3'd1, 4'd0};
    else                        inc7 = v + 7'd1;
  endfunction

  function automatic logic hit(input logic [7:0] v, input logic [7:0] a);
    hit = (a[7:6] == 2'b11) || (v == a);
  endfunction

  logic [7:0] f1, f11, f12, f59, hr_n;
  logic c_s, c_m, c_h, c_d, clr, amatch, irqf;

  assign f1  = fmt(8'd1, dm);
  assign f11 = fmt(8'd11, dm);
  assign f12 = fmt(8'd12, dm);
  assign f59 = fmt(8'd59, dm);
  assign c_s = sec_q == f59;
  assign c_m = min_q == f59;
  assign c_d = day_q == fmt(DMAX, dm);

  always_comb begin
    c_h  = 1'b0;
    hr_n = hr_q;
    if (h24) begin
      hr_n = nxt(hr_q, 8'd23, 8'd0, dm);
      c_h  = hr_q == fmt(8'd23, dm);
    end else if ({1'b0, hr_q[6:0]} == f11) begin
      hr_n = {~hr_q[7], 7'd0} | f12;
      c_h  = hr_q[7];
    end else if ({1'b0, hr_q[6:0]} == f12) begin
      hr_n = {hr_q[7], 7'd0} | f1;
    end else begin
      hr_n = {hr_q[7], inc7(hr_q[6:0], dm)};
    end
  end

  always_ff @(posedge clk) begin
    if (tick_1hz && !set_q) begin
      sec_q <= nxt(sec_q, 8'd59, 8'd0, dm);
      if (c_s) begin
        min_q <= nxt(min_q, 8'd59, 8'd0, dm);
        if (c_m) begin
          hr_q <= hr_n;
          if (c_h) begin
            day_q <= nxt(day_q, DMAX, 8'd1, dm);
            if (c_d) mon_q <= nxt(mon_q, 8'd12, 8'd1, dm);
          end
        end
      end
    end
    if (wr_en)
      case (addr)
        4'd0: sec_q <= wdata;
        4'd1: al_s  <= wdata;
        4'd2: min_q <= wdata;
        4'd3: al_m  <= wdata;
        4'd4: hr_q  <= wdata;
        4'd5: al_h  <= wdata;
        4'd6: day_q <= wdata;
        4'd7: mon_q <= wdata;
        4'd8: begin set_q <= wdata[7]; dm <= wdata[2]; h24 <= wdata[1]; end
        default: ;
      endcase
  end

  assign clr    = rd_en && addr == 4'd9;
  assign amatch = hit(sec_q, al_s) && hit(min_q, al_m) && hit(hr_q, al_h);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      {pie, aie, uie, pf, af, uf, upd_q} <= '0;
    end else begin
      upd_q <= tick_1hz && !set_q;
      if (wr_en && addr == 4'd8) begin
        pie <= wdata[6];
        aie <= wdata[5];
        uie <= wdata[4] && !(wdata[7] && !set_q);
      end
      pf <= (pf && !clr) || tick_per;
      uf <= (uf && !clr) || (upd_q && !set_q);
      af <= (af && !clr) || (upd_q && !set_q && amatch);
    end
  end

  assign irqf  = (pf && pie) || (af && aie) || (uf && uie);
  assign irq_n = !irqf;

  always_comb
    case (addr)
      4'd0: rdata = sec_q;
      4'd1: rdata = al_s;
      4'd2: rdata = min_q;
      4'd3: rdata = al_m;
      4'd4: rdata = hr_q;
      4'd5: rdata = al_h;
      4'd6: rdata = day_q;
      4'd7: rdata = mon_q;
      4'd8: rdata = {set_q, pie, aie, uie, 1'b0, dm, h24, 1'b0};
      4'd9: rdata = {irqf, pf, af, uf, 4'd0};
      default: rdata = 8'd0;
    endcase
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk (
  input logic       clk,
  input logic       por_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [3:0] addr,
  input logic       tick_per,
  input logic [7:0] rdata,
  input logic       irq_n,
  input logic       set_q,
  input logic       uie_q,
  input logic       upd_q,
  input logic       uf_q,
  input logic       pf_q,
  input logic [7:0] sec_q,
  input logic [7:0] min_q,
  input logic [7:0] hr_q
);
  p_frozen_r2: assert property (@(posedge clk) disable iff (!por_n)
    (set_q && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hr_q)));

  p_periodic_r8: assert property (@(posedge clk) disable iff (!por_n)
    tick_per |=> pf_q);

  p_update_flag_r7: assert property (@(posedge clk) disable iff (!por_n)
    (upd_q && !set_q) |=> uf_q);

  p_uie_clear_r12: assert property (@(posedge clk) disable iff (!por_n)
    $rose(set_q) |-> !uie_q);

  p_read_clear_r9: assert property (@(posedge clk) disable iff (!por_n)
    (rd_en && addr == 4'd9 && !tick_per && !upd_q) |=> irq_n);

  p_ctrl_zero_r10: assert property (@(posedge clk) disable iff (!por_n)
    (addr == 4'd8) |-> (rdata[3] == 1'b0 && rdata[0] == 1'b0));

  p_por_quiet_r11: assert property (@(posedge clk)
    !por_n |-> irq_n);
endmodule

bind rtc_core rtc_core_chk u_chk (
  .clk(clk), .por_n(por_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .tick_per(tick_per), .rdata(rdata), .irq_n(irq_n), .set_q(set_q),
  .uie_q(uie), .upd_q(upd_q), .uf_q(uf), .pf_q(pf),
  .sec_q(sec_q), .min_q(min_q), .hr_q(hr_q)
);

// File: tb/rtc_core_test.sv
module rtc_core_test;
  logic clk = 1'b0, por_n = 1'b0, tick_1hz = 1'b0, tick_per = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'd0, rdata;
  logic irq_n;
  int checks = 0, fails = 0;

  rtc_core #(.DAYS(30)) uut (.*);

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rdclr(output logic [7:0] d);
    @(negedge clk); addr = 4'd9; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  task automatic load(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(4'd4, h); wr(4'd2, m); wr(4'd0, s);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R11 irq_n in reset", {7'd0, irq_n}, 8'd1);
    @(negedge clk); por_n = 1'b1;
    wr(4'd8, 8'h06);
    rd(4'd8, d); chk("R10 ctrl after reset", d, 8'h06);
    rd(4'd9, d); chk("R11 flags after reset", d, 8'h00);
  endtask

  task automatic t_bcd_r3();
    logic [7:0] d;
    wr(4'd8, 8'h02); load(8'h05, 8'h10, 8'h09); tick();
    rd(4'd0, d); chk("R3 bcd 09->10", d, 8'h10);
    wr(4'd0, 8'h59); tick();
    rd(4'd0, d); chk("R1 bcd sec wrap", d, 8'h00);
    rd(4'd2, d); chk("R1 bcd min carry", d, 8'h11);
  endtask

  task automatic t_bin_r3();
    logic [7:0] d;
    wr(4'd8, 8'h06); load(8'd5, 8'd59, 8'd9); tick();
    rd(4'd0, d); chk("R3 bin 9->10", d, 8'd10);
    wr(4'd0, 8'd59); tick();
    rd(4'd2, d); chk("R1 bin min wrap", d, 8'd0);
    rd(4'd4, d); chk("R1 bin hour carry", d, 8'd6);
  endtask

  task automatic t_24h_r4();
    logic [7:0] d;
    wr(4'd8, 8'h02); wr(4'd6, 8'h05); wr(4'd7, 8'h03);
    load(8'h23, 8'h59, 8'h59); tick();
    rd(4'd4, d); chk("R4 hour wrap", d, 8'h00);
    rd(4'd6, d); chk("R4 day carry", d, 8'h06);
  endtask

  task automatic t_12h_r5();
    logic [7:0] d;
    wr(4'd8, 8'h00); wr(4'd6, 8'h05);
    load(8'h11, 8'h59, 8'h59); tick();
    rd(4'd4, d); chk("R5 11AM->12PM", d, 8'h92);
    rd(4'd6, d); chk("R5 no day carry at noon", d, 8'h05);
    load(8'h92, 8'h59, 8'h59); tick();
    rd(4'd4, d); chk("R5 12PM->1PM", d, 8'h81);
    load(8'h91, 8'h59, 8'h59); tick();
    rd(4'd4, d); chk("R5 11PM->12AM", d, 8'h12);
    rd(4'd6, d); chk("R5 midnight day carry", d, 8'h06);
  endtask

  task automatic t_cal_r13();
    logic [7:0] d;
    wr(4'd8, 8'h02); wr(4'd6, 8'h30); wr(4'd7, 8'h12);
    load(8'h23, 8'h59, 8'h59); tick();
    rd(4'd6, d); chk("R13 day wrap", d, 8'h01);
    rd(4'd7, d); chk("R13 month wrap", d, 8'h01);
  endtask

  task automatic t_freeze_r2();
    logic [7:0] d;
    wr(4'd8, 8'h02); load(8'h01, 8'h02, 8'h03); rdclr(d);
    wr(4'd8, 8'h82); tick(); tick(); @(negedge clk);
    rd(4'd0, d); chk("R2 frozen sec", d, 8'h03);
    rd(4'd9, d); chk("R7 no update flag when frozen", d, 8'h00);
    wr(4'd0, 8'h44);
    rd(4'd0, d); chk("R2 write while frozen", d, 8'h44);
    wr(4'd8, 8'h02);
  endtask

  task automatic t_uf_r7();
    logic [7:0] d;
    wr(4'd8, 8'h12); rdclr(d); tick();
    chk("R7 irq not yet", {7'd0, irq_n}, 8'd1);
    @(negedge clk);
    chk("R9 irq low on update", {7'd0, irq_n}, 8'd0);
    rdclr(d); chk("R7 flags read", d, 8'h90);
    chk("R9 irq high after read", {7'd0, irq_n}, 8'd1);
    rd(4'd9, d); chk("R9 flags cleared", d, 8'h00);
  endtask

  task automatic t_alarm_r6();
    logic [7:0] d;
    wr(4'd8, 8'h22); wr(4'd1, 8'h05); wr(4'd3, 8'h20); wr(4'd5, 8'h10);
    load(8'h10, 8'h20, 8'h04); rdclr(d); tick(); @(negedge clk);
    chk("R6 alarm irq", {7'd0, irq_n}, 8'd0);
    rdclr(d); chk("R6 alarm flags", d, 8'hB0);
    tick(); @(negedge clk);
    rdclr(d); chk("R6 mismatch no alarm", d, 8'h10);
    wr(4'd1, 8'hC0); tick(); @(negedge clk);
    rdclr(d); chk("R6 wildcard sec", d, 8'hB0);
    tick(); @(negedge clk);
    rdclr(d); chk("R6 wildcard again", d, 8'hB0);
    wr(4'd5, 8'h11); tick(); @(negedge clk);
    rdclr(d); chk("R6 hour mismatch", d, 8'h10);
  endtask

  task automatic t_per_r8();
    logic [7:0] d;
    wr(4'd8, 8'h02); rdclr(d);
    @(negedge clk); tick_per = 1'b1; @(negedge clk); tick_per = 1'b0;
    chk("R8 disabled irq stays high", {7'd0, irq_n}, 8'd1);
    rdclr(d); chk("R8 flag set while disabled", d, 8'h40);
    wr(4'd8, 8'h42);
    @(negedge clk); tick_per = 1'b1; @(negedge clk); tick_per = 1'b0;
    chk("R9 periodic irq", {7'd0, irq_n}, 8'd0);
    rdclr(d); chk("R9 periodic flags", d, 8'hC0);
    chk("R9 irq released", {7'd0, irq_n}, 8'd1);
  endtask

  task automatic t_por_r11();
    logic [7:0] d;
    wr(4'd8, 8'h76); wr(4'd0, 8'd33);
    @(negedge clk); por_n = 1'b0; @(negedge clk); por_n = 1'b1;
    rd(4'd8, d); chk("R11 ctrl after por", d, 8'h06);
    rd(4'd0, d); chk("R11 time kept", d, 8'd33);
  endtask

  task automatic t_uie_r12();
    logic [7:0] d;
    wr(4'd8, 8'h12); wr(4'd8, 8'h92);
    rd(4'd8, d); chk("R12 uie cleared on freeze rise", d, 8'h82);
    wr(4'd8, 8'h92);
    rd(4'd8, d); chk("R12 uie kept when already frozen", d, 8'h92);
    wr(4'd8, 8'h02);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_bcd_r3();
    t_bin_r3();
    t_24h_r4();
    t_12h_r5();
    t_cal_r13();
    t_freeze_r2();
    t_uf_r7();
    t_alarm_r6();
    t_per_r8();
    t_por_r11();
    t_uie_r12();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule